// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a synthesizable model of a small synchronous static RAM. It holds 36-bit words split into four 9-bit lanes, and each lane is 8 data bits plus a parity bit. The RAM samples its address, three chip selects, two address strobes, the advance control and the write controls on the rising clock edge. Read data has no output register: the word at the current address comes straight out of the array and settles within the same cycle. A cache controller or a processor can therefore see the first word one cycle after it presents an address. Each further word of a burst follows one cycle later, giving a 2-1-1-1 burst.

A burst starts on an edge where either address strobe is low. If all three chip selects are true on that edge, the address is captured together with the burst ordering pin. The two low address bits then step through four positions. In linear order they count up with wrap, and in interleaved order they are XORed with a count. Writes are late writes: on a later edge of the burst, the write controls store the data lanes at the current burst address before the address advances.

Output enable and sleep act on the output at once, without a clock edge. While sleep is high, the clock is ignored and the array keeps its contents. The data bus is split into an input port, an output port and a drive flag.

Top module: `ft_burst_sram`

## Requirements
- R1: While reset is low, and after it is released, the output is not driven: `rdata_oe` is 0 and `rdata` is 0.
- R2: On an edge with sleep low and either strobe low (`strb_p_n` or `strb_c_n`), where `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0, the RAM captures `addr_in` and becomes selected. With `oe_n` low, the stored word at that address appears on `rdata` in the same cycle, after the edge.
- R3: A strobe edge where any chip select is false deselects the RAM. `rdata_oe` then stays 0 until a later strobe edge selects it again.
- R4: On an edge with no strobe, the RAM selected, sleep low and `advance_n`=0, the burst count steps by one, modulo 4. The two low address bits then become (start+count) mod 4 when `burst_ilv` was 0 at the strobe edge, or start XOR count when it was 1. The upper address bits never change during a burst.
- R5: Write select on a selected, non-strobe, awake edge works as follows. `gwrite_n`=0 writes all four lanes. Otherwise, when `bwen_n`=0, lane i (`wdata` bits 9i+8..9i) is written where `lane_we_n[i]`=0. Otherwise the cycle is a read. The write goes to the current burst address before any advance.
- R6: A strobe edge never writes, whatever the write controls are.
- R7: On an edge with no strobe, sleep low and `advance_n`=1, the current address is held.
- R8: `rdata_oe` = selected AND NOT `oe_n` AND NOT `sleep`, and it follows `oe_n` with no clock edge. `rdata` is 0 whenever it is not driven.
- R9: While `sleep` is 1, clock edges change neither the address, the selection nor the array. The output is released at once. After wake-up the same word reads back.
- R10: While the RAM is deselected, write controls have no effect on the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the control state |
| addr_in | input | ADDR_W | Word address, captured on strobe edges |
| strb_p_n | input | 1 | Processor-side address strobe, active low |
| strb_c_n | input | 1 | Controller-side address strobe, active low |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Depth chip select, active high |
| sel_c_n | input | 1 | Depth chip select, active low |
| advance_n | input | 1 | Burst advance, active low |
| burst_ilv | input | 1 | Burst order at strobe: 1 interleaved, 0 linear |
| gwrite_n | input | 1 | Write all lanes, active low |
| bwen_n | input | 1 | Enables per-lane writes, active low |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep, active high |
| wdata | input | LANES*LANE_W | Write data, lane i at bits 9i+8..9i |
| rdata | output | LANES*LANE_W | Read data, 0 when not driven |
| rdata_oe | output | 1 | High when the RAM drives the data bus |

## Verification
A wrong burst count or a wrong captured start address shows as the wrong stored word on `rdata` in the cycle right after the faulty edge. Every address holds a distinct pattern, so the fault is visible in that cycle. A wrong lane decode or a write that should have been blocked changes the stored words. The RAM reads combinationally, so the damage appears either at once at the same address or on the next visit to that word. A selection error or a wrong output-enable term shows on `rdata_oe` within a fraction of a cycle, because the drive flag depends on no register other than the selection.

// File: rtl/ft_sram_pkg.sv
`timescale 1ns/1ps
package ft_sram_pkg;
  localparam int DEF_LANES  = 4;
  localparam int DEF_LANE_W = 9;
  localparam int DEF_ADDR_W = 6;

  // Two-bit burst offset from start position and beat count
  function automatic logic [1:0] burst_ofs(input logic [1:0] start,
                                           input logic [1:0] beat,
                                           input logic ilv);
    return ilv ? (start ^ beat) : 2'(start + beat);
  endfunction

  // Whether one lane is written, given the two-level write controls
  function automatic logic lane_hit(input logic gw_n, input logic bw_n,
                                    input logic we_n);
    return ~gw_n | (~bw_n & ~we_n);
  endfunction
endpackage

// File: rtl/sram_addr_ctl.sv
`timescale 1ns/1ps
module sram_addr_ctl
  import ft_sram_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic              strb_p_n,
  input  logic              strb_c_n,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              advance_n,
  input  logic              ilv_mode,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              active,
  output logic              load,
  output logic              step
);
  logic              strobe_any;
  logic              chip_ok;
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        beat_q;
  logic              ilv_q;

  assign strobe_any = ~strb_p_n | ~strb_c_n;
  assign chip_ok    = ~sel_a_n & sel_b & ~sel_c_n;
  assign load       = strobe_any & ~sleep;
  assign step       = active & ~load & ~advance_n & ~sleep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      base_q <= '0;
      beat_q <= 2'd0;
      ilv_q  <= 1'b0;
    end else if (load) begin
      active <= chip_ok;
      if (chip_ok) begin
        base_q <= addr_in;
        beat_q <= 2'd0;
        ilv_q  <= ilv_mode;
      end
    end else if (step) begin
      beat_q <= beat_q + 2'd1;
    end
  end

  assign cur_addr = {base_q[ADDR_W-1:2], burst_ofs(base_q[1:0], beat_q, ilv_q)};

  // R3: a strobe without full selection leaves the RAM deselected
  p_deselect_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !chip_ok) |=> !active);
  // R4: an advance keeps the upper bits and moves the low two bits
  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2]))
             && (cur_addr[1:0] != $past(cur_addr[1:0])));
  // R7: no strobe and no advance holds the address
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(cur_addr));
  // R9: sleep freezes the address and selection
  p_sleep_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> ($stable(cur_addr) && $stable(active)));
endmodule

// File: rtl/sram_wr_dec.sv
`timescale 1ns/1ps
module sram_wr_dec
  import ft_sram_pkg::*;
#(
  parameter int LANES = DEF_LANES
) (
  input  logic             active,
  input  logic             load,
  input  logic             sleep,
  input  logic             gwrite_n,
  input  logic             bwen_n,
  input  logic [LANES-1:0] lane_we_n,
  output logic [LANES-1:0] lane_wr
);
  logic wr_window;

  // Writes happen only on selected, awake, non-strobe edges
  assign wr_window = active & ~load & ~sleep;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_wr[g] = wr_window & lane_hit(gwrite_n, bwen_n, lane_we_n[g]);
  end
endmodule

// File: rtl/sram_array.sv
`timescale 1ns/1ps
module sram_array
  import ft_sram_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int LANES  = DEF_LANES,
  parameter int LANE_W = DEF_LANE_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        lane_wr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rd_word
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_bank
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (lane_wr[g]) mem[addr] <= wdata[g*LANE_W +: LANE_W];
    end
    assign rd_word[g*LANE_W +: LANE_W] = mem[addr];
  end

  // R6, R10: an edge without a lane write leaves the addressed word unchanged
  p_nowrite_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_wr == '0) |=> ((addr != $past(addr)) || (rd_word == $past(rd_word))));
  // R5: a full write stores the whole word
  p_fullwrite_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (&lane_wr) |=> ((addr != $past(addr)) || (rd_word == $past(wdata))));
endmodule

// File: rtl/ft_burst_sram.sv
`timescale 1ns/1ps
module ft_burst_sram
  import ft_sram_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int LANES  = DEF_LANES,
  parameter int LANE_W = DEF_LANE_W,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              strb_p_n,
  input  logic              strb_c_n,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              advance_n,
  input  logic              burst_ilv,
  input  logic              gwrite_n,
  input  logic              bwen_n,
  input  logic [LANES-1:0]  lane_we_n,
  input  logic              oe_n,
  input  logic              sleep,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic              rdata_oe
);
  logic [ADDR_W-1:0] cur_addr;
  logic              active;
  logic              load;
  logic              step;
  logic [LANES-1:0]  lane_wr;
  logic [WORD_W-1:0] arr_word;

  sram_addr_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .sleep(sleep),
    .strb_p_n(strb_p_n), .strb_c_n(strb_c_n),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .advance_n(advance_n), .ilv_mode(burst_ilv), .addr_in(addr_in),
    .cur_addr(cur_addr), .active(active), .load(load), .step(step)
  );

  sram_wr_dec #(.LANES(LANES)) u_dec (
    .active(active), .load(load), .sleep(sleep),
    .gwrite_n(gwrite_n), .bwen_n(bwen_n), .lane_we_n(lane_we_n),
    .lane_wr(lane_wr)
  );

  sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .addr(cur_addr), .lane_wr(lane_wr),
    .wdata(wdata), .rd_word(arr_word)
  );

  // Flow-through read path with asynchronous enable
  assign rdata_oe = active & ~oe_n & ~sleep;
  assign rdata    = rdata_oe ? arr_word : '0;

  // R8, R9: sleep releases the bus regardless of the other controls
  p_sleep_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !rdata_oe);
  // R8: output enable high never drives the bus
  p_oe_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (!rdata_oe && rdata == '0));
endmodule

// File: tb/ft_burst_sram_test.sv
`timescale 1ns/1ps
module ft_burst_sram_test;
  localparam int AW = 6;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr_in;
  logic          strb_p_n, strb_c_n, sel_a_n, sel_b, sel_c_n;
  logic          advance_n, burst_ilv, gwrite_n, bwen_n;
  logic [3:0]    lane_we_n;
  logic          oe_n, sleep;
  logic [35:0]   wdata;
  logic [35:0]   rdata;
  logic          rdata_oe;

  int checks = 0;
  int errors = 0;

  // Reference state
  logic          m_act;
  logic [AW-1:0] m_base;
  logic [1:0]    m_cnt;
  logic          m_ilv;
  logic [35:0]   m_mem [NW];
  bit            m_known [NW];

  ft_burst_sram uut (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
    .strb_p_n(strb_p_n), .strb_c_n(strb_c_n),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .advance_n(advance_n), .burst_ilv(burst_ilv),
    .gwrite_n(gwrite_n), .bwen_n(bwen_n), .lane_we_n(lane_we_n),
    .oe_n(oe_n), .sleep(sleep), .wdata(wdata),
    .rdata(rdata), .rdata_oe(rdata_oe)
  );

  always #10 clk = ~clk;

  function automatic logic [1:0] ofs_model(logic [1:0] s, logic [1:0] n, logic ilv);
    if (ilv) return {s[1] ^ n[1], s[0] ^ n[0]};
    return 2'((int'(s) + int'(n)) % 4);
  endfunction

  function automatic logic [AW-1:0] cur_model();
    return {m_base[AW-1:2], ofs_model(m_base[1:0], m_cnt, m_ilv)};
  endfunction

  function automatic logic [35:0] pattern(int a);
    return 36'(a) * 36'h0_1234_5677 + 36'h9;
  endfunction

  task automatic model_edge();
    logic [AW-1:0] ca;
    logic [3:0] mask;
    if (!rst_n) begin
      m_act = 0; m_base = '0; m_cnt = 0; m_ilv = 0;
    end else if (!sleep) begin
      if (!strb_p_n || !strb_c_n) begin
        if (!sel_a_n && sel_b && !sel_c_n) begin
          m_act = 1; m_base = addr_in; m_cnt = 0; m_ilv = burst_ilv;
        end else m_act = 0;
      end else if (m_act) begin
        ca = cur_model();
        if (!gwrite_n) mask = 4'hF;
        else if (!bwen_n) mask = ~lane_we_n;
        else mask = 4'h0;
        for (int i = 0; i < 4; i++)
          if (mask[i]) m_mem[ca][i*9 +: 9] = wdata[i*9 +: 9];
        if (mask == 4'hF) m_known[ca] = 1;
        if (!advance_n) m_cnt = m_cnt + 2'd1;
      end
    end
  endtask

  task automatic compare(input string tag);
    logic eoe;
    logic [AW-1:0] ca;
    eoe = m_act && !oe_n && !sleep && rst_n;
    ca = cur_model();
    checks++;
    if (rdata_oe !== eoe) begin
      errors++;
      $display("FAIL %s rdata_oe=%b expected %b", tag, rdata_oe, eoe);
    end else if (eoe && m_known[ca] && rdata !== m_mem[ca]) begin
      errors++;
      $display("FAIL %s addr=%0d rdata=%h expected %h", tag, ca, rdata, m_mem[ca]);
    end else if (!eoe && rdata !== 36'h0) begin
      errors++;
      $display("FAIL %s undriven rdata=%h expected 0", tag, rdata);
    end
  endtask

  task automatic cyc(input string tag);
    @(posedge clk);
    model_edge();
    #5;
    compare(tag);
  endtask

  task automatic idle();
    strb_p_n = 1; strb_c_n = 1; sel_a_n = 0; sel_b = 1; sel_c_n = 0;
    advance_n = 1; gwrite_n = 1; bwen_n = 1; lane_we_n = 4'hF;
    oe_n = 0; sleep = 0;
  endtask

  task automatic start(input int a, input logic ilv, input logic use_p, input string tag);
    idle();
    addr_in = AW'(a); burst_ilv = ilv;
    if (use_p) strb_p_n = 0; else strb_c_n = 0;
    cyc(tag);
    idle();
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < NW; i++) begin m_known[i] = 0; m_mem[i] = '0; end
    idle(); addr_in = '0; burst_ilv = 0; wdata = '0; rst_n = 0;
    m_act = 0; m_base = '0; m_cnt = 0; m_ilv = 0;
    cyc("R1"); cyc("R1");
    #5 rst_n = 1;
    cyc("R1");

    // Preload every word with a distinct pattern (R5 full writes)
    for (int b = 0; b < NW / 4; b++) begin
      start(b * 4, 0, b[0], "R2");
      for (int k = 0; k < 4; k++) begin
        gwrite_n = 0; advance_n = 0; wdata = pattern(b * 4 + k);
        cyc("R5");
      end
      idle();
    end

    // R2 first beat, R4 interleaved order from start 2: 2,3,0,1
    start(6, 1, 1, "R2");
    for (int k = 0; k < 3; k++) begin advance_n = 0; cyc("R4"); end
    // R4 linear order from start 3: 3,0,1,2, then wrap
    start(11, 0, 0, "R2");
    for (int k = 0; k < 5; k++) begin advance_n = 0; cyc("R4"); end
    // R7 hold
    idle(); cyc("R7"); cyc("R7");

    // R5 lane writes 1 and 3, then controls without bwen_n are a read
    start(20, 0, 0, "R2");
    bwen_n = 0; lane_we_n = 4'b0101; wdata = 36'h5_A5A5_A5A5; cyc("R5");
    idle(); bwen_n = 1; lane_we_n = 4'h0; wdata = 36'hF_FFFF_FFFF; cyc("R5");
    idle(); cyc("R5");

    // R6 strobe with write controls set
    idle(); strb_c_n = 0; addr_in = 6'd30; gwrite_n = 0; wdata = 36'h0_0000_0BAD;
    cyc("R6");
    idle(); cyc("R6");

    // R8 asynchronous output enable
    oe_n = 1; #1 compare("R8");
    oe_n = 0; #1 compare("R8");

    // R9 sleep: output released at once, edges ignored
    sleep = 1; #1 compare("R9");
    gwrite_n = 0; advance_n = 0; wdata = 36'h1_2345_6789; cyc("R9");
    strb_p_n = 0; addr_in = 6'd1; cyc("R9");
    idle(); #1 compare("R9");
    cyc("R9");

    // R3 deselect, R10 writes ignored while deselected
    idle(); strb_p_n = 0; sel_b = 0; cyc("R3");
    idle(); gwrite_n = 0; advance_n = 0; wdata = 36'h0_DEAD_BEEF; cyc("R10");
    idle(); cyc("R3");
    start(30, 0, 1, "R10");
    start(31, 0, 0, "R10");

    // Constrained random mix
    for (int n = 0; n < 3000; n++) begin
      strb_p_n  = ($urandom % 12) != 0;
      strb_c_n  = ($urandom % 12) != 0;
      sel_a_n   = ($urandom % 8) == 0;
      sel_b     = ($urandom % 8) != 0;
      sel_c_n   = ($urandom % 8) == 0;
      advance_n = ($urandom % 3) == 0;
      burst_ilv = 1'($urandom);
      gwrite_n  = ($urandom % 4) != 0;
      bwen_n    = 1'($urandom);
      lane_we_n = 4'($urandom);
      oe_n      = ($urandom % 5) == 0;
      sleep     = ($urandom % 10) == 0;
      addr_in   = AW'($urandom);
      wdata     = {4'($urandom), 32'($urandom)};
      cyc("R5");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired, no completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule